// File: doc/BRIEF.md
# Execution Privilege Mode Controller

This block decides what the processor may touch at each moment, based only on where instructions are fetched from. It leaves reset in firmware mode with full rights. The first valid fetch from an address outside the ROM range moves it to application mode. That move also sets a sticky lock flag, and only reset clears the flag. From then on, the one-time-writable registers are frozen: the application start and length, the two entry pointers, the secret words and the two RAM scramble seeds. The identity words also become unreadable.

While in application mode, a fetch at one of two registered entry addresses inside ROM raises privilege for a while. The system-call entry restores ROM execution and firmware RAM and SPI access. The hash entry restores ROM execution only. Neither entry unlocks the protected registers. The raised privilege lasts until a fetch leaves the ROM range, and the block then drops back to application rights. The privilege outputs are decoded from registered state, so they change on the clock edge that captures the fetch.

Software reaches the block through a simple register bus. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `exec_priv_ctrl`

## Requirements
- R1: After reset the block is in firmware mode: rom_exec_en, fwram_en, spi_en and prot_wr_en are all 1, and the status register at offset 0x08 reads 0.
- R2: A fetch with fetch_valid high and fetch_addr outside [ROM_BASE, ROM_LAST] moves the block to application mode at that clock edge, and the status register then reads 1. Fetches inside ROM, and any address presented while fetch_valid is low, leave firmware mode in place.
- R3: In application mode rom_exec_en, fwram_en, spi_en and prot_wr_en are all 0. A fetch inside ROM that matches neither entry pointer changes nothing.
- R4: Before the lock is set, writes take effect and read back. This covers offsets 0x0c (app start), 0x0d (app length), 0x10 (hash pointer), 0x12 (syscall pointer) and 0x20+i (secret word i, eight words). Seed writes to 0x40 (address seed) and 0x41 (data seed) appear on ram_addr_seed and ram_data_seed.
- R5: Once the lock is set, writes to every offset listed in R4 are ignored, in application mode and in raised modes alike. Both seed outputs stay stable.
- R6: The syscall and hash pointers reset to ILLEGAL_PTR (default 0xFFFFFFFF). A pointer is honoured only when the fetch address also lies in ROM, so a pointer that was never set cannot raise privilege.
- R7: In application mode, a valid fetch inside ROM equal to the syscall pointer enters syscall privilege: rom_exec_en=1, fwram_en=1, spi_en=1, prot_wr_en=0, status 1. This check takes priority over the hash pointer.
- R8: In application mode, a valid fetch inside ROM equal to the hash pointer enters hash privilege: rom_exec_en=1, fwram_en=0, spi_en=0, prot_wr_en=0, status 1.
- R9: Raised privilege persists across valid fetches inside ROM, including fetches at the other pointer. It ends at the first valid fetch outside ROM, which restores application rights.
- R10: The identity words at 0x30 (low word of ID_INIT) and 0x31 (high word) read their values only before the lock is set. They read 0 afterwards, raised privilege included.
- R11: Seed offsets 0x40 and 0x41 and unmapped offsets always read 0. Writes to the status offset 0x08 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Qualifies fetch_addr as an instruction fetch this cycle |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| reg_addr | input | 8 | Register bus word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| rom_exec_en | output | 1 | ROM may be executed |
| fwram_en | output | 1 | Firmware RAM is visible |
| spi_en | output | 1 | SPI controller is visible |
| prot_wr_en | output | 1 | Protected registers may be written |
| ram_addr_seed | output | DATA_W | RAM address scramble seed |
| ram_data_seed | output | DATA_W | RAM data scramble seed |

## Verification
The hardest states to reach from the ports are the two raised modes. They need entry pointers loaded before the lock, then a fetch outside ROM, and then a fetch that hits a pointer exactly inside ROM. The stimulus loads both pointers in firmware mode and walks one fetch table through every mode change, including a fetch at the hash pointer while already in syscall mode. It also resets the block a second time to show that an unset pointer at its illegal default never raises privilege. Locked-write checks are repeated from inside syscall mode, where the bus rights are widest.

// File: rtl/epc_pkg.sv
// Package: shared mode encoding and register offsets for the execution
// privilege mode controller. Assumes a word-addressed 8-bit register bus.
package epc_pkg;

    typedef enum logic [1:0] {
        MODE_FW      = 2'd0,
        MODE_APP     = 2'd1,
        MODE_SYSCALL = 2'd2,
        MODE_HASH    = 2'd3
    } priv_mode_e;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_STATUS    = 8'h08;
    localparam logic [REG_AW-1:0] OFS_APP_BASE  = 8'h0c;
    localparam logic [REG_AW-1:0] OFS_APP_LEN   = 8'h0d;
    localparam logic [REG_AW-1:0] OFS_HASH_PTR  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_SYS_PTR   = 8'h12;
    localparam logic [REG_AW-1:0] OFS_SECRET0   = 8'h20;
    localparam logic [REG_AW-1:0] OFS_ID0       = 8'h30;
    localparam logic [REG_AW-1:0] OFS_SEED_ADDR = 8'h40;
    localparam logic [REG_AW-1:0] OFS_SEED_DATA = 8'h41;

endpackage

// File: rtl/epc_mode_tracker.sv
// Module: epc_mode_tracker
// Tracks the privilege mode from the instruction fetch stream and holds the
// sticky lock flag that marks the first move out of firmware mode.
// Assumes fetch_addr is meaningful only while fetch_valid is high, and that
// ROM occupies the inclusive range [ROM_BASE, ROM_LAST].
module epc_mode_tracker
    import epc_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] ROM_BASE = '0,
    parameter logic [ADDR_W-1:0] ROM_LAST = 32'h0000_1FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [ADDR_W-1:0] sys_ptr,
    input  logic [ADDR_W-1:0] hash_ptr,
    output priv_mode_e        mode,
    output logic              locked
);

    localparam logic [ADDR_W-1:0] ROM_SPAN = ROM_LAST - ROM_BASE;

    priv_mode_e        mode_q;
    priv_mode_e        mode_nxt;
    logic              locked_q;
    logic [ADDR_W-1:0] rom_ofs;
    logic              in_rom;
    logic              hit_sys;
    logic              hit_hash;

    // Range test done as one subtraction so a zero base needs no compare.
    always_comb begin
        rom_ofs  = fetch_addr - ROM_BASE;
        in_rom   = (rom_ofs <= ROM_SPAN);
        hit_sys  = in_rom && (fetch_addr == sys_ptr);   // R6, R7
        hit_hash = in_rom && (fetch_addr == hash_ptr);  // R6, R8
    end

    // Next-mode decision for a qualified fetch.
    always_comb begin
        mode_nxt = mode_q;
        if (fetch_valid) begin
            unique case (mode_q)
                MODE_FW: begin
                    if (!in_rom) mode_nxt = MODE_APP;            // R2
                end
                MODE_APP: begin
                    if (hit_sys)       mode_nxt = MODE_SYSCALL;  // R7 priority
                    else if (hit_hash) mode_nxt = MODE_HASH;     // R8
                end
                MODE_SYSCALL, MODE_HASH: begin
                    if (!in_rom) mode_nxt = MODE_APP;            // R9
                end
                default: mode_nxt = MODE_APP;
            endcase
        end
    end

    // Mode register; reset lands in firmware mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FW;                           // R1
        else        mode_q <= mode_nxt;
    end

    // Sticky lock: set on the first departure from firmware mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                     locked_q <= 1'b0;
        else if (mode_nxt != MODE_FW)   locked_q <= 1'b1;
    end

    assign mode   = mode_q;
    assign locked = locked_q;

endmodule

// File: rtl/epc_guard_regs.sv
// Module: epc_guard_regs
// Holds the one-time-writable registers: app start and length, the two entry
// pointers, the secret words and the two RAM scramble seeds. Writes land only
// while wr_allow is high. Assumes the caller drives wr_allow low for good once
// the lock flag is set.
module epc_guard_regs
    import epc_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter int                SECRET_WORDS = 8,
    parameter logic [DATA_W-1:0] ILLEGAL_PTR  = 32'hFFFF_FFFF
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic                                 wr_allow,
    input  logic [REG_AW-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [DATA_W-1:0]                    app_base,
    output logic [DATA_W-1:0]                    app_len,
    output logic [DATA_W-1:0]                    hash_ptr,
    output logic [DATA_W-1:0]                    sys_ptr,
    output logic [SECRET_WORDS-1:0][DATA_W-1:0]  secret,
    output logic [DATA_W-1:0]                    seed_addr,
    output logic [DATA_W-1:0]                    seed_data
);

    logic wr_ok;

    // A write is accepted only while the lock is clear (R4, R5).
    assign wr_ok = wr_en && wr_allow;

    // App start and length words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_base <= '0;
            app_len  <= '0;
        end else if (wr_ok) begin
            if (wr_addr == OFS_APP_BASE) app_base <= wr_data;
            if (wr_addr == OFS_APP_LEN)  app_len  <= wr_data;
        end
    end

    // Entry pointers; reset to the illegal value (R6).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_ptr <= ILLEGAL_PTR;
            sys_ptr  <= ILLEGAL_PTR;
        end else if (wr_ok) begin
            if (wr_addr == OFS_HASH_PTR) hash_ptr <= wr_data;
            if (wr_addr == OFS_SYS_PTR)  sys_ptr  <= wr_data;
        end
    end

    // Scramble seeds, driven straight out to the RAM scrambler.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_addr <= '0;
            seed_data <= '0;
        end else if (wr_ok) begin
            if (wr_addr == OFS_SEED_ADDR) seed_addr <= wr_data;
            if (wr_addr == OFS_SEED_DATA) seed_data <= wr_data;
        end
    end

    // One register per secret word at consecutive offsets.
    for (genvar g = 0; g < SECRET_WORDS; g++) begin : g_secret
        localparam logic [REG_AW-1:0] OFS = REG_AW'(int'(OFS_SECRET0) + g);
        // Capture secret word g.
        always_ff @(posedge clk) begin
            if (!rst_n)                       secret[g] <= '0;
            else if (wr_ok && wr_addr == OFS) secret[g] <= wr_data;
        end
    end

endmodule

// File: rtl/epc_read_mux.sv
// Module: epc_read_mux
// Combinational read path. Returns zero for write-only seeds, unmapped
// offsets, and identity words once the lock is set. Assumes the identity
// words are fixed at build time through ID_INIT, word 0 in the low bits.
module epc_read_mux
    import epc_pkg::*;
#(
    parameter int                          DATA_W       = 32,
    parameter int                          SECRET_WORDS = 8,
    parameter int                          ID_WORDS     = 2,
    parameter logic [ID_WORDS*DATA_W-1:0]  ID_INIT      = 64'h0
) (
    input  logic [REG_AW-1:0]                   rd_addr,
    input  logic                                locked,
    input  logic [DATA_W-1:0]                   app_base,
    input  logic [DATA_W-1:0]                   app_len,
    input  logic [DATA_W-1:0]                   hash_ptr,
    input  logic [DATA_W-1:0]                   sys_ptr,
    input  logic [SECRET_WORDS-1:0][DATA_W-1:0] secret,
    output logic [DATA_W-1:0]                   rd_data
);

    // Select the addressed word; anything not matched stays zero (R11).
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            OFS_STATUS:   rd_data = {{(DATA_W-1){1'b0}}, locked};
            OFS_APP_BASE: rd_data = app_base;
            OFS_APP_LEN:  rd_data = app_len;
            OFS_HASH_PTR: rd_data = hash_ptr;
            OFS_SYS_PTR:  rd_data = sys_ptr;
            default:      rd_data = '0;
        endcase
        for (int i = 0; i < SECRET_WORDS; i++) begin
            if (rd_addr == REG_AW'(int'(OFS_SECRET0) + i)) rd_data = secret[i];
        end
        for (int j = 0; j < ID_WORDS; j++) begin
            // Identity hidden once locked (R10).
            if (!locked && rd_addr == REG_AW'(int'(OFS_ID0) + j))
                rd_data = ID_INIT[j*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/exec_priv_ctrl.sv
// Module: exec_priv_ctrl (top)
// Derives memory and register privileges from the instruction fetch stream.
// It combines the mode tracker, the one-time-writable register file and the
// read mux. Assumes a single-cycle register bus with combinational read data.
module exec_priv_ctrl
    import epc_pkg::*;
#(
    parameter int                         ADDR_W       = 32,
    parameter int                         DATA_W       = 32,
    parameter int                         SECRET_WORDS = 8,
    parameter int                         ID_WORDS     = 2,
    parameter logic [ADDR_W-1:0]          ROM_BASE     = '0,
    parameter logic [ADDR_W-1:0]          ROM_LAST     = 32'h0000_1FFF,
    parameter logic [DATA_W-1:0]          ILLEGAL_PTR  = 32'hFFFF_FFFF,
    parameter logic [ID_WORDS*DATA_W-1:0] ID_INIT      = 64'hC0DE_7A11_5EED_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rom_exec_en,
    output logic              fwram_en,
    output logic              spi_en,
    output logic              prot_wr_en,
    output logic [DATA_W-1:0] ram_addr_seed,
    output logic [DATA_W-1:0] ram_data_seed
);

    priv_mode_e                          mode;
    logic                                locked;
    logic [DATA_W-1:0]                   app_base;
    logic [DATA_W-1:0]                   app_len;
    logic [DATA_W-1:0]                   hash_ptr;
    logic [DATA_W-1:0]                   sys_ptr;
    logic [SECRET_WORDS-1:0][DATA_W-1:0] secret;

    epc_mode_tracker #(
        .ADDR_W   (ADDR_W),
        .ROM_BASE (ROM_BASE),
        .ROM_LAST (ROM_LAST)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .sys_ptr     (ADDR_W'(sys_ptr)),
        .hash_ptr    (ADDR_W'(hash_ptr)),
        .mode        (mode),
        .locked      (locked)
    );

    epc_guard_regs #(
        .DATA_W       (DATA_W),
        .SECRET_WORDS (SECRET_WORDS),
        .ILLEGAL_PTR  (ILLEGAL_PTR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_allow  (!locked),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .app_base  (app_base),
        .app_len   (app_len),
        .hash_ptr  (hash_ptr),
        .sys_ptr   (sys_ptr),
        .secret    (secret),
        .seed_addr (ram_addr_seed),
        .seed_data (ram_data_seed)
    );

    epc_read_mux #(
        .DATA_W       (DATA_W),
        .SECRET_WORDS (SECRET_WORDS),
        .ID_WORDS     (ID_WORDS),
        .ID_INIT      (ID_INIT)
    ) u_rd (
        .rd_addr  (reg_addr),
        .locked   (locked),
        .app_base (app_base),
        .app_len  (app_len),
        .hash_ptr (hash_ptr),
        .sys_ptr  (sys_ptr),
        .secret   (secret),
        .rd_data  (reg_rdata)
    );

    // Privilege decode from the registered mode (R1, R3, R7, R8).
    always_comb begin
        rom_exec_en = 1'b0;
        fwram_en    = 1'b0;
        spi_en      = 1'b0;
        prot_wr_en  = 1'b0;
        unique case (mode)
            MODE_FW: begin
                rom_exec_en = 1'b1;
                fwram_en    = 1'b1;
                spi_en      = 1'b1;
                prot_wr_en  = 1'b1;
            end
            MODE_SYSCALL: begin
                rom_exec_en = 1'b1;
                fwram_en    = 1'b1;
                spi_en      = 1'b1;
            end
            MODE_HASH: rom_exec_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/epc_checker.sv
// Module: epc_checker
// Property checks for exec_priv_ctrl, attached through bind. Observes the
// ports plus the internal lock flag.
module epc_checker #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] ROM_BASE = '0,
    parameter logic [ADDR_W-1:0] ROM_LAST = 32'h0000_1FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [7:0]        reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              rom_exec_en,
    input logic              fwram_en,
    input logic              spi_en,
    input logic              prot_wr_en,
    input logic [DATA_W-1:0] ram_addr_seed,
    input logic [DATA_W-1:0] ram_data_seed,
    input logic              locked
);

    logic [ADDR_W-1:0] ofs;
    logic              in_rom;
    logic              id_hit;

    // Independent ROM range and identity-offset decode for the properties.
    always_comb begin
        ofs    = fetch_addr - ROM_BASE;
        in_rom = (ofs <= (ROM_LAST - ROM_BASE));
        id_hit = (reg_addr == 8'h30) || (reg_addr == 8'h31);
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);  // R2

    AST_LOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(fetch_valid) && !$past(in_rom)));  // R2

    AST_EXIT_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !in_rom) |=> (!rom_exec_en && !fwram_en && !spi_en && locked));  // R9

    AST_RAISE_IN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $rose(rom_exec_en)) |-> ($past(fetch_valid) && $past(in_rom)));  // R7

    AST_NO_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr_en |-> !locked);  // R5

    AST_SEED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(ram_addr_seed) && $stable(ram_data_seed)));  // R5

    AST_BUS_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (fwram_en || spi_en) |-> rom_exec_en);  // R8

    AST_ID_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && id_hit) |-> (reg_rdata == '0));  // R10

endmodule

bind exec_priv_ctrl epc_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ROM_BASE (ROM_BASE),
    .ROM_LAST (ROM_LAST)
) u_epc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .fetch_addr    (fetch_addr),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .rom_exec_en   (rom_exec_en),
    .fwram_en      (fwram_en),
    .spi_en        (spi_en),
    .prot_wr_en    (prot_wr_en),
    .ram_addr_seed (ram_addr_seed),
    .ram_data_seed (ram_data_seed),
    .locked        (locked)
);

// File: tb/tb_exec_priv_ctrl.sv
`timescale 1ns/1ps
module tb_exec_priv_ctrl;

    localparam logic [31:0] ILLEGAL = 32'hFFFF_FFFF;
    localparam logic [31:0] ID_LO   = 32'h5EED_0001;
    localparam logic [31:0] ID_HI   = 32'hC0DE_7A11;
    localparam logic [31:0] SYS_AT  = 32'h0000_0100;
    localparam logic [31:0] HASH_AT = 32'h0000_0200;

    // Row: {fetch_valid, fetch_addr, exp rom_exec, fwram, spi, prot_wr, status}
    localparam int ROWS = 14;
    localparam logic [37:0] FT [ROWS] = '{
        {1'b1, 32'h0000_0040, 5'b11110},  // ROM fetch in firmware
        {1'b0, 32'h0000_8000, 5'b11110},  // not qualified
        {1'b1, 32'h0000_0100, 5'b11110},  // pointer hit ignored in firmware
        {1'b1, 32'h0000_8000, 5'b00001},  // leave ROM -> app
        {1'b1, 32'h0000_0040, 5'b00001},  // plain ROM fetch in app
        {1'b0, 32'h0000_0100, 5'b00001},  // unqualified pointer hit
        {1'b1, 32'h0000_0100, 5'b11101},  // syscall entry
        {1'b1, 32'h0000_0104, 5'b11101},  // stays in ROM
        {1'b1, 32'h0000_0200, 5'b11101},  // hash pointer while in syscall
        {1'b1, 32'h0000_8004, 5'b00001},  // leave ROM -> app
        {1'b1, 32'h0000_0200, 5'b10001},  // hash entry
        {1'b1, 32'h0000_0210, 5'b10001},  // stays in ROM
        {1'b1, 32'h0000_9000, 5'b00001},  // leave ROM -> app
        {1'b1, 32'hFFFF_FFFF, 5'b00001}   // far fetch
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rom_exec_en, fwram_en, spi_en, prot_wr_en;
    logic [31:0] ram_addr_seed, ram_data_seed;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    exec_priv_ctrl dut (
        .clk (clk), .rst_n (rst_n),
        .fetch_valid (fetch_valid), .fetch_addr (fetch_addr),
        .reg_addr (reg_addr), .reg_we (reg_we), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rom_exec_en (rom_exec_en), .fwram_en (fwram_en), .spi_en (spi_en),
        .prot_wr_en (prot_wr_en),
        .ram_addr_seed (ram_addr_seed), .ram_data_seed (ram_data_seed)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fetch_valid = 1'b0;
        reg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fetch(input logic v, input logic [31:0] a);
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    function automatic logic [31:0] privs();
        return {28'b0, rom_exec_en, fwram_en, spi_en, prot_wr_en};
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R1 reset state, R6 pointer defaults
        check("R1 privileges after reset", privs(), 32'hF);
        rd(8'h08, d); check("R1 status after reset", d, 32'h0);
        rd(8'h12, d); check("R6 syscall pointer default", d, ILLEGAL);
        rd(8'h10, d); check("R6 hash pointer default", d, ILLEGAL);

        // R4 writes before lock
        wr(8'h0c, 32'h0000_1000);
        wr(8'h0d, 32'h0000_2345);
        wr(8'h10, HASH_AT);
        wr(8'h12, SYS_AT);
        for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i), 32'hA000_0000 + 32'(i));
        wr(8'h40, 32'h1111_1111);
        wr(8'h41, 32'h2222_2222);
        rd(8'h0c, d); check("R4 app start", d, 32'h0000_1000);
        rd(8'h0d, d); check("R4 app length", d, 32'h0000_2345);
        rd(8'h10, d); check("R4 hash pointer", d, HASH_AT);
        rd(8'h12, d); check("R4 syscall pointer", d, SYS_AT);
        for (int i = 0; i < 8; i++) begin
            rd(8'h20 + 8'(i), d); check("R4 secret word", d, 32'hA000_0000 + 32'(i));
        end
        check("R4 address seed out", ram_addr_seed, 32'h1111_1111);
        check("R4 data seed out", ram_data_seed, 32'h2222_2222);

        // R11 write-only, unmapped, status write
        rd(8'h40, d); check("R11 address seed reads zero", d, 32'h0);
        rd(8'h41, d); check("R11 data seed reads zero", d, 32'h0);
        rd(8'h50, d); check("R11 unmapped reads zero", d, 32'h0);
        wr(8'h08, 32'h1);
        rd(8'h08, d); check("R11 status write ignored", d, 32'h0);
        check("R11 status write keeps firmware rights", privs(), 32'hF);

        // R10 identity visible before lock
        rd(8'h30, d); check("R10 identity low before lock", d, ID_LO);
        rd(8'h31, d); check("R10 identity high before lock", d, ID_HI);

        // R2 R3 R7 R8 R9: fetch table walk
        for (int r = 0; r < ROWS; r++) begin
            fetch(FT[r][37], FT[r][36:5]);
            check($sformatf("R2/R3/R7/R8/R9 fetch row %0d privileges", r),
                  privs(), {28'b0, FT[r][4:1]});
            rd(8'h08, d);
            check($sformatf("R2/R7/R8 fetch row %0d status", r), d, {31'b0, FT[r][0]});
        end

        // R5 writes ignored once locked (app mode)
        wr(8'h0c, 32'hDEAD_0001);
        wr(8'h12, 32'hDEAD_0002);
        wr(8'h23, 32'hDEAD_0003);
        wr(8'h40, 32'hDEAD_0004);
        rd(8'h0c, d); check("R5 app start frozen", d, 32'h0000_1000);
        rd(8'h12, d); check("R5 syscall pointer frozen", d, SYS_AT);
        rd(8'h23, d); check("R5 secret frozen", d, 32'hA000_0003);
        check("R5 address seed frozen", ram_addr_seed, 32'h1111_1111);
        rd(8'h30, d); check("R10 identity low hidden in app", d, 32'h0);

        // R5 R10 inside syscall privilege
        fetch(1'b1, SYS_AT);
        check("R7 syscall rights again", privs(), 32'hE);
        wr(8'h10, 32'hDEAD_0005);
        wr(8'h41, 32'hDEAD_0006);
        rd(8'h10, d); check("R5 hash pointer frozen in syscall", d, HASH_AT);
        check("R5 data seed frozen in syscall", ram_data_seed, 32'h2222_2222);
        rd(8'h31, d); check("R10 identity high hidden in syscall", d, 32'h0);
        rd(8'h41, d); check("R11 data seed reads zero in syscall", d, 32'h0);

        // R6 unset pointers never raise privilege
        do_reset();
        check("R1 privileges after second reset", privs(), 32'hF);
        fetch(1'b1, 32'h0000_8000);
        check("R2 app after second reset", privs(), 32'h0);
        fetch(1'b1, ILLEGAL);
        check("R6 fetch at unset pointer value", privs(), 32'h0);
        fetch(1'b1, 32'h0000_0000);
        check("R6 ROM fetch with unset pointers", privs(), 32'h0);
        rd(8'h08, d); check("R6 status stays application", d, 32'h1);

        report();
    end

endmodule